// File: doc/BRIEF.md
# LDPC Bit Node Update Unit

This block is the variable (bit) node of a min-sum LDPC decoder. In one cycle it takes a node's channel log-likelihood value and up to `MAX_EDGES` incoming check-to-variable messages. An edge-enable mask selects which inputs are live, so columns of different weight can share one unit.

For every enabled edge it returns a variable-to-check message: the channel value plus all live incoming messages, leaving out the message that arrived on that same edge. It also returns a hard bit taken from the full sum. The node function is a plain sum, so it does not depend on which min-sum variant the check nodes use.

An init mode serves the first iteration. In that mode the raw channel value is sent out on every enabled edge and the incoming messages are ignored. Messages are signed fixed-point words of `MSG_W` bits, by default 7 bits with 3 fractional bits, and every output saturates to that range. Results are registered and appear one cycle after the input strobe.

Top module: `ldpc_bitnode_update`

## Requirements
- R1: While `rst_n` is low and after its release, before any `in_valid`, `out_valid` is 0, `hard_bit` is 0 and all of `v2c_flat` is 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 otherwise.
- R3: With `init_mode` high, every enabled edge outputs `chan_llr` unchanged. `hard_bit` is the sign bit of `chan_llr`, and `c2v_flat` has no effect.
- R4: With `init_mode` low, enabled edge e outputs sat(`chan_llr` + sum of enabled incoming messages − incoming message of edge e).
- R5: With `init_mode` low, `hard_bit` is 1 exactly when `chan_llr` plus the sum of enabled incoming messages is negative. This sum is taken at full precision, without saturation, and 0 means bit value 0.
- R6: An edge whose `edge_en` bit is 0 outputs 0, and its incoming message has no effect on any other output or on `hard_bit`.
- R7: Messages are two's-complement words of `MSG_W` bits. Outputs saturate to [−2^(MSG_W−1), 2^(MSG_W−1)−1], which is [−64, 63] by default, so no output wraps.
- R8: In a cycle with `in_valid` low, `v2c_flat` and `hard_bit` keep their previous values whatever the other inputs do.
- R9: Edge e uses bits [e·MSG_W +: MSG_W] of both `c2v_flat` and `v2c_flat`, and bit e of `edge_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe; results are captured in this cycle |
| init_mode | input | 1 | 1: forward the channel value; 0: extrinsic update |
| edge_en | input | MAX_EDGES | Per-edge enable mask |
| chan_llr | input | MSG_W | Channel log-likelihood value, signed |
| c2v_flat | input | MAX_EDGES*MSG_W | Incoming check-to-variable messages, packed by edge |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| v2c_flat | output | MAX_EDGES*MSG_W | Outgoing variable-to-check messages, packed by edge |
| hard_bit | output | 1 | Hard decision for the bit |

## Verification
The assertions check the timing rules on every cycle. These are the one-cycle valid latency, holding the outputs when no strobe arrives, zero on disabled edges, and the channel value on enabled edges in init mode. The arithmetic cannot be shown cycle by cycle in the same way: exclusion of each edge's own message, saturation at both ends, and a hard decision taken on an unsaturated total. The bench shows these by sweeping every enable mask against random and extreme message values, including sums well beyond the message range.

// File: rtl/bnu_pkg.sv
package bnu_pkg;

  typedef enum logic {
    BNU_ITER = 1'b0,
    BNU_INIT = 1'b1
  } bnu_mode_e;

  // Width that holds the channel value plus all edge messages without overflow.
  function automatic int acc_width(input int msg_w, input int edges);
    return msg_w + $clog2(edges + 1);
  endfunction

endpackage

// File: rtl/bnu_sum_tree.sv
module bnu_sum_tree
  import bnu_pkg::*;
#(
  parameter int MSG_W     = 7,
  parameter int MAX_EDGES = 4,
  localparam int ACC_W    = acc_width(MSG_W, MAX_EDGES)
) (
  input  logic signed [MSG_W-1:0]           chan,
  input  logic [MAX_EDGES*MSG_W-1:0]        msgs_in,
  input  logic [MAX_EDGES-1:0]              enables,
  output logic signed [ACC_W-1:0]           total
);

  logic signed [ACC_W-1:0] term [MAX_EDGES];

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [MSG_W-1:0] v);
    return ACC_W'(v);
  endfunction

  for (genvar e = 0; e < MAX_EDGES; e++) begin : g_term
    logic signed [MSG_W-1:0] word;
    assign word    = msgs_in[e*MSG_W +: MSG_W];
    assign term[e] = enables[e] ? widen(word) : '0;
  end

  always_comb begin
    total = widen(chan);
    for (int e = 0; e < MAX_EDGES; e++) begin
      total = total + term[e];
    end
  end

endmodule

// File: rtl/bnu_edge_out.sv
module bnu_edge_out
  import bnu_pkg::*;
#(
  parameter int MSG_W     = 7,
  parameter int MAX_EDGES = 4,
  localparam int ACC_W    = acc_width(MSG_W, MAX_EDGES)
) (
  input  logic signed [ACC_W-1:0] total,
  input  logic signed [MSG_W-1:0] own_msg,
  input  logic signed [MSG_W-1:0] chan,
  input  bnu_mode_e               mode,
  input  logic                    enable,
  output logic signed [MSG_W-1:0] msg_out,
  output logic                    sat_hit
);

  localparam logic signed [ACC_W-1:0] MSG_HI = ACC_W'((1 <<< (MSG_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MSG_LO = -ACC_W'(1 <<< (MSG_W - 1));

  function automatic logic signed [MSG_W-1:0] clip(input logic signed [ACC_W-1:0] v);
    if (v > MSG_HI)      return MSG_HI[MSG_W-1:0];
    else if (v < MSG_LO) return MSG_LO[MSG_W-1:0];
    else                 return v[MSG_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] extrinsic;

  assign extrinsic = total - ACC_W'(own_msg);
  assign sat_hit   = enable && (mode == BNU_ITER) &&
                     ((extrinsic > MSG_HI) || (extrinsic < MSG_LO));

  always_comb begin
    if (!enable)                msg_out = '0;
    else if (mode == BNU_INIT)  msg_out = chan;
    else                        msg_out = clip(extrinsic);
  end

endmodule

// File: rtl/ldpc_bitnode_update.sv
module ldpc_bitnode_update
  import bnu_pkg::*;
#(
  parameter int MSG_W     = 7,
  parameter int MAX_EDGES = 4,
  localparam int ACC_W    = acc_width(MSG_W, MAX_EDGES),
  localparam int BUS_W    = MAX_EDGES * MSG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 init_mode,
  input  logic [MAX_EDGES-1:0] edge_en,
  input  logic [MSG_W-1:0]     chan_llr,
  input  logic [BUS_W-1:0]     c2v_flat,
  output logic                 out_valid,
  output logic [BUS_W-1:0]     v2c_flat,
  output logic                 hard_bit
);

  bnu_mode_e               mode;
  logic signed [ACC_W-1:0] total_sum;
  logic [BUS_W-1:0]        v2c_next;
  logic [MAX_EDGES-1:0]    sat_event;
  logic                    hard_next;

  assign mode = init_mode ? BNU_INIT : BNU_ITER;

  bnu_sum_tree #(.MSG_W(MSG_W), .MAX_EDGES(MAX_EDGES)) sum_i (
    .chan    (chan_llr),
    .msgs_in (c2v_flat),
    .enables (edge_en),
    .total   (total_sum)
  );

  for (genvar e = 0; e < MAX_EDGES; e++) begin : g_edge
    logic signed [MSG_W-1:0] res;
    bnu_edge_out #(.MSG_W(MSG_W), .MAX_EDGES(MAX_EDGES)) edge_i (
      .total   (total_sum),
      .own_msg (c2v_flat[e*MSG_W +: MSG_W]),
      .chan    (chan_llr),
      .mode    (mode),
      .enable  (edge_en[e]),
      .msg_out (res),
      .sat_hit (sat_event[e])
    );
    assign v2c_next[e*MSG_W +: MSG_W] = res;
  end

  assign hard_next = (mode == BNU_INIT) ? chan_llr[MSG_W-1] : total_sum[ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      v2c_flat  <= '0;
      hard_bit  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        v2c_flat <= v2c_next;
        hard_bit <= hard_next;
      end
    end
  end

endmodule

// File: rtl/ldpc_bitnode_update_chk.sv
module ldpc_bitnode_update_chk #(
  parameter int MSG_W     = 7,
  parameter int MAX_EDGES = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         init_mode,
  input logic [MAX_EDGES-1:0]         edge_en,
  input logic [MSG_W-1:0]             chan_llr,
  input logic [MAX_EDGES*MSG_W-1:0]   v2c_flat,
  input logic                         out_valid,
  input logic                         hard_bit
);

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(v2c_flat) && $stable(hard_bit)));

  // R3
  init_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && init_mode) |=> (hard_bit == $past(chan_llr[MSG_W-1])));

  for (genvar e = 0; e < MAX_EDGES; e++) begin : g_edge_chk
    // R6
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !edge_en[e]) |=> (v2c_flat[e*MSG_W +: MSG_W] == '0));

    // R3
    init_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && init_mode && edge_en[e]) |=>
        (v2c_flat[e*MSG_W +: MSG_W] == $past(chan_llr)));
  end

endmodule

bind ldpc_bitnode_update ldpc_bitnode_update_chk #(
  .MSG_W(MSG_W), .MAX_EDGES(MAX_EDGES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .init_mode(init_mode),
  .edge_en(edge_en), .chan_llr(chan_llr), .v2c_flat(v2c_flat),
  .out_valid(out_valid), .hard_bit(hard_bit)
);

// File: tb/ldpc_bitnode_update_tb_top.sv
module ldpc_bitnode_update_tb_top;

  localparam int W = 7;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         init_mode = 1'b0;
  logic [N-1:0] edge_en = '0;
  logic [W-1:0] chan_llr = '0;
  logic [N*W-1:0] c2v_flat = '0;
  logic         out_valid;
  logic [N*W-1:0] v2c_flat;
  logic         hard_bit;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;
  int cv [N];

  always #2 clk = ~clk;

  ldpc_bitnode_update #(.MSG_W(W), .MAX_EDGES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .init_mode(init_mode),
    .edge_en(edge_en), .chan_llr(chan_llr), .c2v_flat(c2v_flat),
    .out_valid(out_valid), .v2c_flat(v2c_flat), .hard_bit(hard_bit)
  );

  function automatic int sat7(input int v);
    if (v > 63) return 63;
    if (v < -64) return -64;
    return v;
  endfunction

  function automatic int pick();
    int r;
    seed = seed * 32'd1103515245 + 32'd12345;
    r = int'(seed >> 16);
    if (r % 6 == 0) return 63;
    if (r % 6 == 1) return -64;
    return ((r >> 3) % 128) - 64;
  endfunction

  function automatic int out_word(input int e);
    logic signed [W-1:0] s;
    s = v2c_flat[e*W +: W];
    return int'(s);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One strobed transaction, then the outputs are compared with arithmetic expectations.
  task automatic run_vec(input bit init, input logic [N-1:0] mask, input int ch);
    int tot;
    @(negedge clk);
    init_mode = init;
    edge_en   = mask;
    chan_llr  = W'(ch);
    for (int e = 0; e < N; e++) c2v_flat[e*W +: W] = W'(cv[e]);
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    tot = ch;
    if (!init) for (int e = 0; e < N; e++) if (mask[e]) tot += cv[e];
    check("R2 out_valid", int'(out_valid), 1);
    for (int e = 0; e < N; e++) begin
      if (!mask[e])  check("R6 disabled edge", out_word(e), 0);
      else if (init) check("R3 init forward", out_word(e), ch);
      else           check("R4/R7 extrinsic", out_word(e), sat7(tot - cv[e]));
    end
    check(init ? "R3 init decision" : "R5 hard decision", int'(hard_bit), (tot < 0) ? 1 : 0);
  endtask

  task automatic hold_check();
    logic [N*W-1:0] keep_v;
    logic keep_h;
    keep_v = v2c_flat;
    keep_h = hard_bit;
    @(negedge clk);
    chan_llr  = ~chan_llr;
    c2v_flat  = ~c2v_flat;
    edge_en   = ~edge_en;
    init_mode = ~init_mode;
    @(negedge clk);
    check("R8 hold messages", int'(v2c_flat != keep_v), 0);
    check("R8 hold decision", int'(hard_bit), int'(keep_h));
    check("R2 no strobe", int'(out_valid), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset msgs", int'(v2c_flat != '0), 0);
    check("R1 reset bit", int'(hard_bit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(out_valid | hard_bit | (|v2c_flat)), 0);

    // R9 field layout: distinct value per edge, all enabled
    cv[0] = 1; cv[1] = 2; cv[2] = 4; cv[3] = 8;
    run_vec(1'b0, 4'hF, 0);
    check("R9 edge0 position", out_word(0), 14);
    check("R9 edge3 position", out_word(3), 7);

    // R7 saturation at both ends, R5 unsaturated total
    for (int e = 0; e < N; e++) cv[e] = 63;
    run_vec(1'b0, 4'hF, 63);
    for (int e = 0; e < N; e++) cv[e] = -64;
    run_vec(1'b0, 4'hF, -64);
    cv[0] = -64; cv[1] = -64; cv[2] = -64; cv[3] = 63;
    run_vec(1'b0, 4'b1000, 10);

    // Sweep every mask in both modes with random and extreme values
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 40; k++) begin
        for (int e = 0; e < N; e++) cv[e] = pick();
        run_vec(k % 8 == 0, 4'(m), pick());
        if (k % 10 == 3) hold_check();
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule